// File: doc/BRIEF.md
# FIFO Threshold DMA Trigger Unit

This unit sits beside the transmit and receive FIFOs of a serial port that can act as bus controller or bus target. It watches the occupancy counts of both FIFOs and turns them into DMA request lines. The receive side asks for service once enough bytes are waiting. The transmit side asks for service once the FIFO has drained far enough. Each direction owns an independent trigger group made of a mask, a raw status, a masked status, a write-one-to-set port and a write-one-to-clear port. A small register bus reaches all of them. A done pulse returned by each DMA channel is captured as a second event in that channel's group.

Status bits are edge-captured. A threshold condition that stays true does not re-arm a bit after software has cleared it. Changing the operating mode between controller and target flushes all pending status, so no request crosses over from one role to the other. The trigger line of a group follows the masked threshold bit of that group.

Top module: `fifo_dma_trigger`

## Requirements
- R1: After reset every mask and raw status bit is 0, the transmit level reads 0 and the receive level reads 1, so the level register reads 8'h10.
- R2: The receive threshold event (bit 0 of the receive group) is set one clock after rxCount >= receive level becomes true, having been false in the previous cycle.
- R3: The transmit threshold event (bit 0 of the transmit group) is set one clock after txCount <= transmit level becomes true, having been false in the previous cycle.
- R4: A raw bit never goes from 0 to 1 without a fresh condition edge, a done pulse or a set write. A level that stays true does not re-set a cleared bit.
- R5: Masked status equals raw AND mask. txTrig and rxTrig equal bit 0 of their group's masked status.
- R6: Writing the set register makes each raw bit high where the written data has a 1. Zero bits leave the raw bit unchanged.
- R7: Writing the clear register makes each raw bit low where the data has a 1. A clear beats a threshold edge, done pulse or set arriving in the same cycle.
- R8: doneTx / doneRx set bit 1 of their group. This bit is masked, set and cleared like bit 0, but it never drives the trigger line.
- R9: Any change of modeSel (0 controller, 1 target) clears all raw bits of both groups on the next clock.
- R10: Address map: transmit group at 0 to 4 and receive group at 5 to 9, with the group offsets mask +0, raw +1, masked +2, set +3, clear +4. Address 10 holds the levels, transmit in bits [2:0] and receive in bits [6:4].
- R11: Reads of set, clear and unmapped addresses return 0. Writes to raw or masked status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 controller role, 1 target role |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| txCount | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| rxCount | input | 4 | Receive FIFO occupancy, 0 to 8 |
| doneTx | input | 1 | Done pulse from the transmit DMA channel |
| doneRx | input | 1 | Done pulse from the receive DMA channel |
| txTrig | output | 1 | Transmit DMA trigger |
| rxTrig | output | 1 | Receive DMA trigger |

## Verification
The assertions watch, on every clock, that a condition edge or done pulse lands in the raw status, that a clear always wins, that a mode change flushes both groups, that no raw bit rises without a cause, and that a trigger never appears without its mask. Only the bench scenarios show the read map and level encoding, the reset values, and the behaviour of the set register against zero data bits. The same holds for the direction of each comparison at its exact boundary, since a reference model checks these cycle by cycle through the register bus.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int NGRP = 2;        // group 0 transmit, group 1 receive
  localparam int GRP_TX = 0;
  localparam int GRP_RX = 1;
  localparam int EVW = 2;         // bit0 threshold, bit1 dma done
  localparam int GRP_STRIDE = 5;
  localparam int OFS_MASK = 0;
  localparam int OFS_RAW = 1;
  localparam int OFS_MIS = 2;
  localparam int OFS_SET = 3;
  localparam int OFS_CLR = 4;
  localparam int ADDR_LVL = NGRP * GRP_STRIDE;
  localparam int RX_LVL_LSB = 4;

  typedef struct packed {
    logic [NGRP-1:0] wrMask;
    logic [NGRP-1:0] wrSet;
    logic [NGRP-1:0] wrClr;
    logic            wrLvl;
    logic            flushAll;
  } trigStrobe_t;
endpackage

// File: rtl/fdt_ctrl.sv
module fdt_ctrl
  import fdt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeSel,
  input  logic          regWr,
  input  logic [AW-1:0] regAddr,
  output trigStrobe_t   stb
);
  logic modePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modePrev <= 1'b0;
    else       modePrev <= modeSel;
  end

  always_comb begin
    stb = '0;
    for (int g = 0; g < NGRP; g++) begin
      stb.wrMask[g] = regWr && (regAddr == AW'(g * GRP_STRIDE + OFS_MASK));
      stb.wrSet[g]  = regWr && (regAddr == AW'(g * GRP_STRIDE + OFS_SET));
      stb.wrClr[g]  = regWr && (regAddr == AW'(g * GRP_STRIDE + OFS_CLR));
    end
    stb.wrLvl    = regWr && (regAddr == AW'(ADDR_LVL));
    stb.flushAll = (modeSel != modePrev);
  end
endmodule

// File: rtl/fdt_datapath.sv
module fdt_datapath
  import fdt_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int TXL_RST = 0,
  parameter int RXL_RST = 1,
  localparam int LVL_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  trigStrobe_t        stb,
  input  logic [AW-1:0]      regAddr,
  input  logic [DW-1:0]      regWrData,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic               doneTx,
  input  logic               doneRx,
  output logic [DW-1:0]      rdData,
  output logic [NGRP-1:0]    trigOut,
  output logic [NGRP*EVW-1:0] rawOut,
  output logic [NGRP*EVW-1:0] maskOut,
  output logic [LVL_W-1:0]   lvlTx,
  output logic [LVL_W-1:0]   lvlRx
);
  logic [CNT_W-1:0] cnt  [NGRP];
  logic [NGRP-1:0]  done;
  logic [DW-1:0]    lvlPacked;

  assign cnt[GRP_TX]  = txCount;
  assign cnt[GRP_RX]  = rxCount;
  assign done[GRP_TX] = doneTx;
  assign done[GRP_RX] = doneRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlTx <= LVL_W'(TXL_RST);
      lvlRx <= LVL_W'(RXL_RST);
    end else if (stb.wrLvl) begin
      lvlTx <= regWrData[LVL_W-1:0];
      lvlRx <= regWrData[RX_LVL_LSB +: LVL_W];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : gGrp
    logic           cond, condPrev;
    logic [EVW-1:0] raw, mask, setVec, clrVec;

    if (g == GRP_TX) begin : gTxCmp
      assign cond = cnt[g] <= CNT_W'(lvlTx);
    end else begin : gRxCmp
      assign cond = cnt[g] >= CNT_W'(lvlRx);
    end

    assign setVec = {done[g], cond && !condPrev}
                  | (stb.wrSet[g] ? regWrData[EVW-1:0] : '0);
    assign clrVec = stb.wrClr[g] ? regWrData[EVW-1:0] : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        condPrev <= 1'b0;
        raw      <= '0;
        mask     <= '0;
      end else begin
        condPrev <= cond;
        raw      <= stb.flushAll ? '0 : ((raw | setVec) & ~clrVec);
        if (stb.wrMask[g]) mask <= regWrData[EVW-1:0];
      end
    end

    assign rawOut[g*EVW +: EVW]  = raw;
    assign maskOut[g*EVW +: EVW] = mask;
    assign trigOut[g]            = raw[0] & mask[0];
  end

  always_comb begin
    lvlPacked = '0;
    lvlPacked[LVL_W-1:0] = lvlTx;
    lvlPacked[RX_LVL_LSB +: LVL_W] = lvlRx;
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (regAddr == AW'(g * GRP_STRIDE + OFS_MASK))
        rdData = DW'(maskOut[g*EVW +: EVW]);
      if (regAddr == AW'(g * GRP_STRIDE + OFS_RAW))
        rdData = DW'(rawOut[g*EVW +: EVW]);
      if (regAddr == AW'(g * GRP_STRIDE + OFS_MIS))
        rdData = DW'(rawOut[g*EVW +: EVW] & maskOut[g*EVW +: EVW]);
    end
    if (regAddr == AW'(ADDR_LVL)) rdData = lvlPacked;
  end
endmodule

// File: rtl/fifo_dma_trigger.sv
module fifo_dma_trigger
  import fdt_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int TXL_RST = 0,
  parameter int RXL_RST = 1,
  localparam int LVL_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             regWr,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    regWrData,
  output logic [DW-1:0]    regRdData,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             doneTx,
  input  logic             doneRx,
  output logic             txTrig,
  output logic             rxTrig
);
  trigStrobe_t         stb;
  logic [NGRP-1:0]     trigVec;
  logic [NGRP*EVW-1:0] rawVec, maskVec;
  logic [LVL_W-1:0]    lvlTx, lvlRx;

  fdt_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regWr(regWr),
    .regAddr(regAddr), .stb(stb)
  );

  fdt_datapath #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .TXL_RST(TXL_RST), .RXL_RST(RXL_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .txCount(txCount), .rxCount(rxCount),
    .doneTx(doneTx), .doneRx(doneRx), .rdData(regRdData),
    .trigOut(trigVec), .rawOut(rawVec), .maskOut(maskVec),
    .lvlTx(lvlTx), .lvlRx(lvlRx)
  );

  assign txTrig = trigVec[GRP_TX];
  assign rxTrig = trigVec[GRP_RX];
endmodule

// File: rtl/fifo_dma_trigger_chk.sv
module fifo_dma_trigger_chk
  import fdt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int LVL_W = 3,
  parameter int CNT_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeSel,
  input logic                regWr,
  input logic [AW-1:0]       regAddr,
  input logic [DW-1:0]       regWrData,
  input logic [CNT_W-1:0]    txCount,
  input logic [CNT_W-1:0]    rxCount,
  input logic                doneTx,
  input logic                doneRx,
  input logic                txTrig,
  input logic                rxTrig,
  input logic [NGRP*EVW-1:0] rawVec,
  input logic [NGRP*EVW-1:0] maskVec,
  input logic [LVL_W-1:0]    lvlTx,
  input logic [LVL_W-1:0]    lvlRx
);
  logic seenTx, seenRx, modeSeen;
  logic condTx, condRx, clrTx0, clrRx0, clrRx1, setTxAny, modeHeld;
  logic [EVW-1:0] rawTx, rawRx;

  assign rawTx    = rawVec[GRP_TX*EVW +: EVW];
  assign rawRx    = rawVec[GRP_RX*EVW +: EVW];
  assign condTx   = txCount <= CNT_W'(lvlTx);
  assign condRx   = rxCount >= CNT_W'(lvlRx);
  assign clrTx0   = regWr && regAddr == AW'(OFS_CLR) && regWrData[0];
  assign clrRx0   = regWr && regAddr == AW'(GRP_STRIDE + OFS_CLR) && regWrData[0];
  assign clrRx1   = regWr && regAddr == AW'(GRP_STRIDE + OFS_CLR) && regWrData[1];
  assign setTxAny = regWr && regAddr == AW'(OFS_SET);
  assign modeHeld = modeSel == modeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenTx <= 1'b0; seenRx <= 1'b0; modeSeen <= 1'b0;
    end else begin
      seenTx <= condTx; seenRx <= condRx; modeSeen <= modeSel;
    end
  end

  AST_RX_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (condRx && !seenRx && !clrRx0 && modeHeld) |=> rawRx[0]); // R2
  AST_TX_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (condTx && !seenTx && !clrTx0 && modeHeld) |=> rawTx[0]); // R3
  AST_NO_CAUSELESS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!doneTx && !(condTx && !seenTx) && !setTxAny)
      |=> ((rawTx & ~$past(rawTx)) == '0)); // R4
  AST_TRIG_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rxTrig |-> (maskVec[GRP_RX*EVW] && rawRx[0])); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrTx0 |=> !rawTx[0]); // R7
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (doneRx && !clrRx1 && modeHeld) |=> rawRx[1]); // R8
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !modeHeld |=> (rawVec == '0)); // R9
endmodule

bind fifo_dma_trigger fifo_dma_trigger_chk #(
  .AW(AW), .DW(DW), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .regWr(regWr),
  .regAddr(regAddr), .regWrData(regWrData), .txCount(txCount),
  .rxCount(rxCount), .doneTx(doneTx), .doneRx(doneRx), .txTrig(txTrig),
  .rxTrig(rxTrig), .rawVec(rawVec), .maskVec(maskVec), .lvlTx(lvlTx),
  .lvlRx(lvlRx)
);

// File: tb/fifo_dma_trigger_bench.sv
module fifo_dma_trigger_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0, regWr = 1'b0, doneTx = 1'b0, doneRx = 1'b0;
  logic [3:0] regAddr = 4'd0, txCount = 4'd3, rxCount = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       txTrig, rxTrig;

  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  int mMask[2], mRaw[2], mPrev[2], mLvl[2];
  int mMode;

  always #5 clk = ~clk;

  fifo_dma_trigger u_fifo_dma_trigger (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txCount(txCount), .rxCount(rxCount), .doneTx(doneTx), .doneRx(doneRx),
    .txTrig(txTrig), .rxTrig(rxTrig)
  );

  function automatic int modelRead(int a);
    for (int g = 0; g < 2; g++) begin
      if (a == g*5 + 0) return mMask[g];
      if (a == g*5 + 1) return mRaw[g];
      if (a == g*5 + 2) return mRaw[g] & mMask[g];
    end
    if (a == 10) return mLvl[0] | (mLvl[1] << 4);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < 2; g++) begin
        mMask[g] = 0; mRaw[g] = 0; mPrev[g] = 0;
      end
      mLvl[0] = 0; mLvl[1] = 1; mMode = 0;
    end else begin
      int cnd[2];
      cnd[0] = (txCount <= mLvl[0]);
      cnd[1] = (rxCount >= mLvl[1]);
      for (int g = 0; g < 2; g++) begin
        int s, c;
        s = ((g == 0 ? doneTx : doneRx) ? 2 : 0) | ((cnd[g] && !mPrev[g]) ? 1 : 0);
        c = 0;
        if (regWr && regAddr == g*5 + 3) s |= regWrData[1:0];
        if (regWr && regAddr == g*5 + 4) c = regWrData[1:0];
        mRaw[g] = (mRaw[g] | s) & ~c & 3;
        if (modeSel != mMode) mRaw[g] = 0;
        if (regWr && regAddr == g*5) mMask[g] = regWrData[1:0];
        mPrev[g] = cnd[g];
      end
      if (regWr && regAddr == 10) begin
        mLvl[0] = regWrData[2:0];
        mLvl[1] = regWrData[6:4];
      end
      mMode = modeSel;
    end
    #3;
    if (!done) begin
      int eRd, eTx, eRx;
      eRd = modelRead(regAddr);
      eTx = mRaw[0] & mMask[0] & 1;
      eRx = mRaw[1] & mMask[1] & 1;
      vectors++;
      if (regRdData !== 8'(eRd) || txTrig !== eTx[0] || rxTrig !== eRx[0]) begin
        fails++;
        $display("FAIL %s addr=%0d rd=%h/%h txTrig=%b/%b rxTrig=%b/%b (actual/expected)",
                 phase, regAddr, regRdData, 8'(eRd), txTrig, eTx[0], rxTrig, eRx[0]);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(int a, int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 4'(a); regWrData = 8'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic look(int a, int n);
    @(negedge clk);
    regAddr = 4'(a);
    step(n);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    phase = "R1";   look(10, 2); look(0, 1); look(1, 1); look(6, 1);
    phase = "R2";   look(6, 1);
    for (int c = 0; c <= 5; c++) begin rxCount = 4'(c); step(1); end
    look(6, 2);
    phase = "R5";   wrReg(5, 1); look(7, 2);
    phase = "R4";   wrReg(9, 1); look(6, 3); rxCount = 4'd7; step(2);
    phase = "R10";  wrReg(10, 8'h32); look(10, 1);
    phase = "R2";   rxCount = 4'd2; step(1); rxCount = 4'd3; look(6, 2);
    phase = "R3";   wrReg(0, 3); look(1, 1);
    for (int c = 8; c >= 0; c--) begin txCount = 4'(c); step(1); end
    look(2, 2); wrReg(4, 3); look(1, 2);
    phase = "R6";   txCount = 4'd8; wrReg(3, 0); look(1, 1); wrReg(3, 2); look(2, 2);
    phase = "R7";   @(negedge clk); txCount = 4'd2; doneTx = 1'b1;
    regWr = 1'b1; regAddr = 4'd4; regWrData = 8'd3;
    @(negedge clk); regWr = 1'b0; doneTx = 1'b0; regAddr = 4'd1; step(2);
    phase = "R8";   look(6, 1); doneRx = 1'b1; step(1); doneRx = 1'b0; look(6, 1);
    wrReg(5, 2); look(7, 2); wrReg(9, 2); look(6, 1);
    phase = "R9";   wrReg(3, 3); wrReg(8, 3); look(1, 1); modeSel = 1'b1; step(2);
    look(6, 1); modeSel = 1'b0; step(2);
    phase = "R11";  wrReg(8, 3); wrReg(1, 3); wrReg(2, 3); look(1, 1);
    for (int a = 3; a <= 15; a++) if (a != 5 && a != 6 && a != 7 && a != 10) look(a, 1);
    phase = "R3";   wrReg(10, 8'h10); txCount = 4'd1; step(2); txCount = 4'd0; look(1, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    while (!done && cycles < 5000) begin @(posedge clk); cycles++; end
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog %s expired after %0d cycles (expected completion)", phase, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule